// File: doc/BRIEF.md
# Segment LCD Frame Timing and Pixel Write Window

This block produces the frame timing for a multiplexed segment LCD driver. A free-running position counter divides each frame into one to four equal common-line phases and marks each frame boundary. A parity bit groups frames into even/odd pairs. When alternating two-frame drive is in use, a pixel must stay unchanged across both frames of a pair. In that mode the block raises a one-cycle frame interrupt near the end of every odd frame. After the interrupt it opens a short write window during which new pixel data may be stored.

Pixel write requests are judged against that window. A request inside the window is acknowledged. A request outside it is refused and latches a sticky error flag, which stays set until software clears it. With single-frame drive, or with a single common line, no interrupt is produced and writes are never gated. The analog drive levels and the pixel storage belong to neighbouring blocks.

Top module: `lcd_frame_ctl`

## Requirements
- R1: After a synchronous reset, every output is low and `com_idx` is 0.
- R2: While enabled, `com_idx` runs 0 up to `mux_sel`. Each phase lasts FRAME_LEN/(`mux_sel`+1) cycles, and the index returns to 0 when a new frame starts.
- R3: `frame_mark` is high for exactly the first cycle of every frame that follows a completed frame. Its period is FRAME_LEN cycles, and it never coincides with a nonzero `com_idx`.
- R4: With `wave_b`=1 and `mux_sel`≠0, `frame_irq` is a one-cycle pulse issued once per two frames, only in the odd frame. It is seen exactly LEAD_UNIT*(`mux_sel`+1) cycles before the next `frame_mark`.
- R5: With `wave_b`=0, or with `mux_sel`=0, `frame_irq` stays low.
- R6: `wr_window` rises in the cycle after `frame_irq` and stays high for exactly WIN_LEN cycles.
- R7: In gated mode (`wave_b`=1, `mux_sel`≠0), a `pix_wr` request sampled while `wr_window` is high gives a one-cycle `wr_ack` in the next cycle.
- R8: A refused `pix_wr` request gives no `wr_ack` and sets `wr_err` in the next cycle.
- R9: While enabled in ungated mode, every `pix_wr` request is acknowledged in the next cycle and never sets `wr_err`.
- R10: `wr_err` holds until an `err_clr` strobe clears it. A refused request in the same cycle as `err_clr` leaves `wr_err` set.
- R11: While `en` is low, counters sit at COM0 of an even frame. No interrupt or mark is produced, the window is closed, and every request is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds timing at its start point |
| wave_b | input | 1 | 1 selects two-frame alternating drive, 0 single-frame drive |
| mux_sel | input | 2 | Number of common lines minus one |
| pix_wr | input | 1 | Pixel write request |
| err_clr | input | 1 | Clears the error flag |
| frame_irq | output | 1 | One-cycle frame interrupt |
| wr_window | output | 1 | High while pixel writes are allowed |
| wr_ack | output | 1 | One-cycle write acceptance |
| wr_err | output | 1 | Sticky refused-write flag |
| com_idx | output | 2 | Active common phase |
| frame_mark | output | 1 | First cycle of a new frame |

## Verification
`frame_irq`, `frame_mark`, `com_idx`, `wr_ack` and `wr_err` are registered, so each reacts to counter state and inputs one clock edge after they are sampled. `wr_window` follows `frame_irq` by one edge. The bench drives inputs on the falling edge and keeps a cycle-level arithmetic model that advances on each rising edge from those same inputs. It compares all six outputs on the next falling edge, so every result is checked in the cycle it is due. The sweep covers both drive types, all four multiplex settings, a mid-run disable and requests that coincide with clears.

// File: rtl/lcdf_pkg.sv
package lcdf_pkg;
  typedef logic [1:0] mux_t;

  function automatic logic gate_on(input logic wave_b, input mux_t mux);
    return wave_b && (mux != 2'd0);
  endfunction
endpackage

// File: rtl/lcdf_timebase.sv
module lcdf_timebase
  import lcdf_pkg::*;
#(
  parameter int FRAME_LEN = 48,
  localparam int POS_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  mux_t             mux_sel,
  output logic [POS_W-1:0] pos_o,
  output logic             par_o,
  output logic [1:0]       com_o,
  output logic             mark_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);
  localparam logic [POS_W-1:0] PEND0 = POS_W'(FRAME_LEN - 1);
  localparam logic [POS_W-1:0] PEND1 = POS_W'(FRAME_LEN / 2 - 1);
  localparam logic [POS_W-1:0] PEND2 = POS_W'(FRAME_LEN / 3 - 1);
  localparam logic [POS_W-1:0] PEND3 = POS_W'(FRAME_LEN / 4 - 1);

  logic [POS_W-1:0] ph_cnt;
  logic [POS_W-1:0] ph_end;
  logic             last;

  always_comb begin
    case (mux_sel)
      2'd0:    ph_end = PEND0;
      2'd1:    ph_end = PEND1;
      2'd2:    ph_end = PEND2;
      default: ph_end = PEND3;
    endcase
  end

  assign last = (pos_o == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pos_o  <= '0;
      ph_cnt <= '0;
      com_o  <= 2'd0;
      par_o  <= 1'b0;
      mark_o <= 1'b0;
    end else begin
      mark_o <= last;
      if (last) begin
        pos_o  <= '0;
        ph_cnt <= '0;
        com_o  <= 2'd0;
        par_o  <= ~par_o;
      end else begin
        pos_o <= pos_o + 1'b1;
        if (ph_cnt >= ph_end) begin
          ph_cnt <= '0;
          com_o  <= com_o + 2'd1;
        end else begin
          ph_cnt <= ph_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lcdf_irq_gen.sv
module lcdf_irq_gen
  import lcdf_pkg::*;
#(
  parameter int FRAME_LEN = 48,
  parameter int LEAD_UNIT = 4,
  parameter int WIN_LEN   = 9,
  localparam int POS_W = $clog2(FRAME_LEN),
  localparam int WIN_W = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             gated,
  input  mux_t             mux_sel,
  input  logic [POS_W-1:0] pos,
  input  logic             par,
  output logic             irq_o,
  output logic             win_o
);
  localparam logic [POS_W-1:0] TRIG0 = POS_W'(FRAME_LEN - LEAD_UNIT * 1 - 1);
  localparam logic [POS_W-1:0] TRIG1 = POS_W'(FRAME_LEN - LEAD_UNIT * 2 - 1);
  localparam logic [POS_W-1:0] TRIG2 = POS_W'(FRAME_LEN - LEAD_UNIT * 3 - 1);
  localparam logic [POS_W-1:0] TRIG3 = POS_W'(FRAME_LEN - LEAD_UNIT * 4 - 1);
  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WIN_LEN);

  logic [POS_W-1:0] trig;
  logic [WIN_W-1:0] win_cnt;

  always_comb begin
    case (mux_sel)
      2'd0:    trig = TRIG0;
      2'd1:    trig = TRIG1;
      2'd2:    trig = TRIG2;
      default: trig = TRIG3;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      irq_o   <= 1'b0;
      win_cnt <= '0;
    end else begin
      irq_o <= gated && par && (pos == trig);
      if (irq_o)
        win_cnt <= WIN_LOAD;
      else if (win_cnt != '0)
        win_cnt <= win_cnt - 1'b1;
    end
  end

  assign win_o = (win_cnt != '0);
endmodule

// File: rtl/lcdf_write_gate.sv
module lcdf_write_gate (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic gated,
  input  logic win,
  input  logic pix_wr,
  input  logic err_clr,
  output logic ack_o,
  output logic err_o
);
  logic allow;
  assign allow = en && (!gated || win);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o <= 1'b0;
      err_o <= 1'b0;
    end else begin
      ack_o <= pix_wr && allow;
      if (pix_wr && !allow)
        err_o <= 1'b1;
      else if (err_clr)
        err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_frame_ctl.sv
module lcd_frame_ctl
  import lcdf_pkg::*;
#(
  parameter int FRAME_LEN = 48,
  parameter int LEAD_UNIT = 4,
  parameter int WIN_LEN   = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       wave_b,
  input  logic [1:0] mux_sel,
  input  logic       pix_wr,
  input  logic       err_clr,
  output logic       frame_irq,
  output logic       wr_window,
  output logic       wr_ack,
  output logic       wr_err,
  output logic [1:0] com_idx,
  output logic       frame_mark
);
  localparam int POS_W = $clog2(FRAME_LEN);

  logic [POS_W-1:0] pos;
  logic             par;
  logic             gated;

  assign gated = gate_on(wave_b, mux_sel);

  lcdf_timebase #(.FRAME_LEN(FRAME_LEN)) u_tb (
    .clk(clk), .rst(rst), .en(en), .mux_sel(mux_sel),
    .pos_o(pos), .par_o(par), .com_o(com_idx), .mark_o(frame_mark)
  );

  lcdf_irq_gen #(.FRAME_LEN(FRAME_LEN), .LEAD_UNIT(LEAD_UNIT), .WIN_LEN(WIN_LEN)) u_irq (
    .clk(clk), .rst(rst), .en(en), .gated(gated), .mux_sel(mux_sel),
    .pos(pos), .par(par), .irq_o(frame_irq), .win_o(wr_window)
  );

  lcdf_write_gate u_wg (
    .clk(clk), .rst(rst), .en(en), .gated(gated), .win(wr_window),
    .pix_wr(pix_wr), .err_clr(err_clr), .ack_o(wr_ack), .err_o(wr_err)
  );
endmodule

// File: rtl/lcd_frame_ctl_chk.sv
module lcd_frame_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       wave_b,
  input logic [1:0] mux_sel,
  input logic       pix_wr,
  input logic       err_clr,
  input logic       frame_irq,
  input logic       wr_window,
  input logic       wr_ack,
  input logic       wr_err,
  input logic [1:0] com_idx,
  input logic       frame_mark
);
  a_r4_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
    frame_irq |=> !frame_irq);

  a_r5_irq_needs_gating: assert property (@(posedge clk) disable iff (rst)
    frame_irq |-> $past(en && wave_b && (mux_sel != 2'd0)));

  a_r6_window_follows_irq: assert property (@(posedge clk) disable iff (rst)
    (frame_irq && en) |=> wr_window);

  a_r7_ack_was_allowed: assert property (@(posedge clk) disable iff (rst)
    wr_ack |-> $past(pix_wr && en && (wr_window || !wave_b || (mux_sel == 2'd0))));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_err) && !$past(err_clr)) |-> wr_err);

  a_r11_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> (com_idx == 2'd0 && !frame_irq && !wr_ack && !frame_mark && !wr_window));

  a_r3_mark_at_com0: assert property (@(posedge clk) disable iff (rst)
    frame_mark |-> (com_idx == 2'd0));
endmodule

bind lcd_frame_ctl lcd_frame_ctl_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .wave_b(wave_b), .mux_sel(mux_sel),
  .pix_wr(pix_wr), .err_clr(err_clr), .frame_irq(frame_irq),
  .wr_window(wr_window), .wr_ack(wr_ack), .wr_err(wr_err),
  .com_idx(com_idx), .frame_mark(frame_mark)
);

// File: tb/lcd_frame_ctl_test.sv
module lcd_frame_ctl_test;
  localparam int F    = 48;
  localparam int LU   = 4;
  localparam int WL   = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, wave_b = 1'b0, pix_wr = 1'b0, err_clr = 1'b0;
  logic [1:0] mux_sel = 2'd0;
  logic frame_irq, wr_window, wr_ack, wr_err, frame_mark;
  logic [1:0] com_idx;

  int errors = 0;
  int checks = 0;

  // reference state
  int m_pos, m_ph, m_com, m_par, m_irq, m_win, m_mark, m_ack, m_err;
  logic l_en, l_gate, l_clr;

  always #5 clk = ~clk;

  lcd_frame_ctl #(.FRAME_LEN(F), .LEAD_UNIT(LU), .WIN_LEN(WL)) uut (
    .clk(clk), .rst(rst), .en(en), .wave_b(wave_b), .mux_sel(mux_sel),
    .pix_wr(pix_wr), .err_clr(err_clr), .frame_irq(frame_irq),
    .wr_window(wr_window), .wr_ack(wr_ack), .wr_err(wr_err),
    .com_idx(com_idx), .frame_mark(frame_mark)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_pos = 0; m_ph = 0; m_com = 0; m_par = 0;
    m_irq = 0; m_win = 0; m_mark = 0; m_ack = 0; m_err = 0;
  endtask

  // advance the model by one rising edge using the current inputs
  task automatic model_step();
    int n = int'(mux_sel) + 1;
    int plen = F / n;
    int lead = LU * n;
    bit gate = wave_b && (mux_sel != 2'd0);
    bit allow = en && (!gate || (m_win != 0));
    int n_irq, n_win;
    if (pix_wr && !allow) m_err = 1;
    else if (err_clr) m_err = 0;
    m_ack = (pix_wr && allow) ? 1 : 0;
    if (!en) begin
      m_pos = 0; m_ph = 0; m_com = 0; m_par = 0;
      m_irq = 0; m_win = 0; m_mark = 0;
    end else begin
      n_irq = (gate && m_par == 1 && m_pos == F - lead - 1) ? 1 : 0;
      n_win = (m_irq != 0) ? WL : ((m_win > 0) ? m_win - 1 : 0);
      m_irq = n_irq;
      m_win = n_win;
      m_mark = (m_pos == F - 1) ? 1 : 0;
      if (m_pos == F - 1) begin
        m_pos = 0; m_ph = 0; m_com = 0; m_par = 1 - m_par;
      end else begin
        m_pos++;
        if (m_ph >= plen - 1) begin m_ph = 0; m_com++; end
        else m_ph++;
      end
    end
    l_en = en; l_gate = gate; l_clr = err_clr;
  endtask

  task automatic compare();
    chk(l_en ? (l_gate ? "R4" : "R5") : "R11", int'(frame_irq), m_irq);
    chk(l_en ? "R6" : "R11", int'(wr_window), (m_win != 0) ? 1 : 0);
    chk(!l_en ? "R11" : (l_gate ? "R7" : "R9"), int'(wr_ack), m_ack);
    chk(l_clr ? "R10" : "R8", int'(wr_err), m_err);
    chk(l_en ? "R2" : "R11", int'(com_idx), m_com);
    chk(l_en ? "R3" : "R11", int'(frame_mark), m_mark);
  endtask

  initial begin : watchdog
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", int'({frame_irq, wr_window, wr_ack, wr_err, frame_mark}), 0);
    chk("R1", int'(com_idx), 0);
    rst = 1'b0;
    l_en = 1'b0; l_gate = 1'b0; l_clr = 1'b0;
    for (int t = 0; t < 2; t++) begin
      for (int m = 0; m < 4; m++) begin
        for (int k = 0; k < 5 * F + 20; k++) begin
          // drive on the falling edge
          wave_b  = (t == 1);
          mux_sel = 2'(m);
          en      = (k >= 4) && !(k >= 150 && k < 157);
          pix_wr  = (k % 7 == 3) || (k % 11 == 0);
          err_clr = (k % 13 == 6) || (k % 29 == 3);
          @(posedge clk);
          model_step();
          @(negedge clk);
          compare();
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule